// File: doc/BRIEF.md
# Configurable Synchronous Serial Shift Engine

This block moves one word at a time over a full-duplex synchronous serial link. On each frame a word goes out on the serial data output while a word is collected from the serial data input. The engine can own the shift clock as master, dividing the system clock down, or it can follow a shift clock supplied from outside as slave. In slave mode that clock is brought into the system domain through a synchroniser.

A control word selects five things at run time: the role, the idle level of the clock, which clock edge samples and which one changes data, the bit order, and the frame length, which is 2 to 16 bits. A parallel write loads the word to send. The received word appears on a parallel output together with a one-cycle valid pulse. Sticky flags report a write made while busy and a received word that overwrote one nobody had read.

The control word is latched when a frame starts, so it can be rewritten during a frame without effect on that frame. The enable bit is the exception: it is checked live.

Top module: `sync_serial_engine`

## Requirements
- R1: After reset the control word is all zeros. The engine is disabled, so a transmit write starts nothing. busy, rx_valid, tx_err and rx_ovr are 0 and sclk_out is 0.
- R2: The control word is written through ctl_wdata with these fields: bit 0 enable, bit 1 master, bit 2 idle level, bit 3 phase, bit 4 MSB-first, bits 8:5 width code. A frame has width code + 1 bits and 2·(code+1) clock edges. A transmit write with width code 0 starts no frame.
- R3: When no frame is active, sclk_out rests at the idle-level bit: 0 means it idles low and the leading edge rises, 1 means it idles high and the leading edge falls.
- R4: Phase 0 changes output data on leading edges and samples input on trailing edges. Phase 1 samples on leading edges and changes data on trailing edges. The first bit is on sdo from the moment the word is loaded.
- R5: MSB-first 0 sends and receives the least significant bit first. MSB-first 1 sends and receives the most significant bit first. For a frame of length L, only bits L-1:0 are used, and rx_data bits above L-1 are 0.
- R6: In master mode the shift clock is generated internally, and each half period lasts div_half+1 system cycles. The master samples sdi directly.
- R7: In slave mode the engine shifts on edges of sclk_in after sclk_in and sdi pass through a two-stage synchroniser. The system clock must be at least four times the shift clock.
- R8: With enable clear, transmit writes are ignored. Clearing enable during a frame ends it: busy drops and sclk_out returns to its idle level.
- R9: busy rises the cycle after an accepted transmit write and falls at the frame's final clock edge. At the last sample, rx_data is updated and rx_valid pulses high for one cycle.
- R10: A transmit write while busy sets tx_err and leaves the frame in progress unchanged. tx_err stays set until err_clr.
- R11: If a frame completes while the previous received word has not been acknowledged with rx_read, rx_ovr is set. rx_ovr stays set until err_clr, even after rx_read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Load ctl_wdata into the control word |
| ctl_wdata | input | 9 | Control word value (field layout in R2) |
| div_half | input | DIV_W | Master half period minus one, in system cycles |
| tx_wr | input | 1 | Transmit word write strobe |
| tx_data | input | 16 | Word to send |
| rx_read | input | 1 | Acknowledges the current received word |
| err_clr | input | 1 | Clears tx_err and rx_ovr |
| sclk_in | input | 1 | External shift clock (slave mode) |
| sdi | input | 1 | Serial data in |
| sclk_out | output | 1 | Generated shift clock (master mode), idle level otherwise |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Frame in progress |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |
| tx_err | output | 1 | Sticky write-while-busy flag |
| rx_ovr | output | 1 | Sticky receive overrun flag |

## Verification
The hardest case to reach from the ports is proving that the engine samples on the correct edge for its phase setting. With a plain loopback, data is stable for a whole period, so a design that samples on the wrong edge still returns the right word. In slave runs, the bench therefore acts as an external clock source. For phase 0 it changes sdi midway between the leading and trailing edges. For phase 1 it changes sdi midway between a trailing edge and the next leading edge. A design that samples on the wrong edge then picks up the neighbouring bit. In master runs the bench records sdo on the edges a partner device would sample, and it checks that the divider sets the half period.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    localparam int MAX_LEN = 16;
    localparam int LEN_W   = $clog2(MAX_LEN);
    localparam int EC_W    = LEN_W + 2;

    typedef struct packed {
        logic [LEN_W-1:0] width;
        logic             msb_first;
        logic             cpha;
        logic             cpol;
        logic             master;
        logic             enable;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [LEN_W:0] frame_len(input logic [LEN_W-1:0] code);
        return {1'b0, code} + (LEN_W+1)'(1);
    endfunction

    function automatic logic [LEN_W-1:0] bit_pos(input logic msb,
                                                 input logic [LEN_W:0] len,
                                                 input logic [LEN_W:0] idx);
        logic [LEN_W:0] p;
        p = msb ? (len - idx - (LEN_W+1)'(1)) : idx;
        return p[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/ssx_sync.sv
module ssx_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ssx_clkgen.sv
module ssx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div_half,
    output logic             edge_o,
    output logic             sclk_o
);

    logic [DIV_W-1:0] cnt;
    logic             phase;

    assign edge_o = run && (cnt == div_half);
    assign sclk_o = phase ^ cpol;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (edge_o) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    AST_HALF_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !edge_o) |=> $stable(phase)); // R6

endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter import ssx_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  ctl_t               ctl,
    input  logic               tx_wr,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic               edge_m,
    input  logic               sclk_s,
    input  logic               sdi_s,
    input  logic               sdi_raw,
    input  logic               rx_read,
    input  logic               err_clr,
    output logic               busy,
    output ctl_t               act,
    output logic               sdo,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_valid,
    output logic               tx_err,
    output logic               rx_ovr
);

    logic [MAX_LEN-1:0] tx_q, rx_q, rx_next;
    logic [EC_W-1:0]    ecnt;
    logic [LEN_W:0]     tidx, sidx, len;
    logic [LEN_W-1:0]   rpos, tpos;
    logic               prev_s, full_q, lead, din;
    logic               edge_s, edge_any, samp, shft, final_edge, done, start;

    assign len        = frame_len(act.width);
    assign sidx       = ecnt[EC_W-1:1];
    assign lead       = ~ecnt[0];
    assign edge_s     = sclk_s ^ prev_s;
    assign edge_any   = busy && ctl.enable && (act.master ? edge_m : edge_s);
    assign samp       = edge_any && (lead == act.cpha);
    assign shft       = edge_any && !samp;
    assign final_edge = edge_any && (ecnt == {len, 1'b0} - EC_W'(1));
    assign done       = samp && (sidx == len - (LEN_W+1)'(1));
    assign start      = tx_wr && !busy && ctl.enable && (ctl.width != '0);
    assign din        = act.master ? sdi_raw : sdi_s;
    assign rpos       = bit_pos(act.msb_first, len, sidx);
    assign tpos       = bit_pos(act.msb_first, len, tidx);
    assign sdo        = busy ? tx_q[tpos] : 1'b0;

    always_comb begin
        rx_next       = rx_q;
        rx_next[rpos] = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            act      <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            ecnt     <= '0;
            tidx     <= '0;
            prev_s   <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            prev_s   <= sclk_s;
            rx_valid <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                act  <= ctl;
                tx_q <= tx_data;
                rx_q <= '0;
                ecnt <= '0;
                tidx <= '0;
            end else if (busy && !ctl.enable) begin
                busy <= 1'b0;
            end else if (edge_any) begin
                ecnt <= ecnt + EC_W'(1);
                if (final_edge) busy <= 1'b0;
                if (shft) tidx <= act.cpha ? sidx + (LEN_W+1)'(1) : sidx;
                if (samp) rx_q <= rx_next;
                if (done) begin
                    rx_data  <= rx_next;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_err <= 1'b0;
            rx_ovr <= 1'b0;
            full_q <= 1'b0;
        end else begin
            if (tx_wr && busy)                 tx_err <= 1'b1;
            else if (err_clr)                  tx_err <= 1'b0;
            if (done && full_q && !rx_read)    rx_ovr <= 1'b1;
            else if (err_clr)                  rx_ovr <= 1'b0;
            if (done)                          full_q <= 1'b1;
            else if (rx_read)                  full_q <= 1'b0;
        end
    end

    AST_RESERVED_NO_START: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && !busy && ctl.width == '0) |=> !busy); // R2
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ctl.enable |=> !busy); // R8
    AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(busy)); // R9
    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ecnt < {len, 1'b0})); // R9
    AST_TXERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tx_err && !err_clr) |=> tx_err); // R10
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rx_ovr && !err_clr) |=> rx_ovr); // R11

endmodule

// File: rtl/sync_serial_engine.sv
module sync_serial_engine import ssx_pkg::*; #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic [DIV_W-1:0]   div_half,
    input  logic               tx_wr,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic               rx_read,
    input  logic               err_clr,
    input  logic               sclk_in,
    input  logic               sdi,
    output logic               sclk_out,
    output logic               sdo,
    output logic               busy,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_valid,
    output logic               tx_err,
    output logic               rx_ovr
);

    ctl_t       ctl, act;
    logic [1:0] sync_q;
    logic       edge_m, cpol_now, run_m;

    always_ff @(posedge clk) begin
        if (rst)         ctl <= '0;
        else if (ctl_wr) ctl <= ctl_t'(ctl_wdata);
    end

    ssx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk_in, sdi}),
        .q   (sync_q)
    );

    assign cpol_now = busy ? act.cpol : ctl.cpol;
    assign run_m    = busy && act.master;

    ssx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (run_m),
        .cpol     (cpol_now),
        .div_half (div_half),
        .edge_o   (edge_m),
        .sclk_o   (sclk_out)
    );

    ssx_shifter u_shifter (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .tx_wr    (tx_wr),
        .tx_data  (tx_data),
        .edge_m   (edge_m),
        .sclk_s   (sync_q[1]),
        .sdi_s    (sync_q[0]),
        .sdi_raw  (sdi),
        .rx_read  (rx_read),
        .err_clr  (err_clr),
        .busy     (busy),
        .act      (act),
        .sdo      (sdo),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .tx_err   (tx_err),
        .rx_ovr   (rx_ovr)
    );

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> (sclk_out == ctl.cpol)); // R3

endmodule

// File: tb/test_sync_serial_engine.sv
`timescale 1ns/1ps
module test_sync_serial_engine;

    typedef struct packed {
        logic        master;
        logic        cpol;
        logic        cpha;
        logic        msb;
        logic [3:0]  width;
        logic [15:0] tx;
        logic [15:0] pat;
        logic [7:0]  div;
    } vec_t;

    localparam int NV = 8;
    localparam int H2 = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 4'd7,  16'h00B4, 16'h0000, 8'd2},
        '{1'b1, 1'b0, 1'b1, 1'b1, 4'd15, 16'hC3A5, 16'h0000, 8'd1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'd3,  16'h000D, 16'h0000, 8'd0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 4'd1,  16'h0002, 16'h0000, 8'd3},
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'd7,  16'h005A, 16'h0093, 8'd0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 4'd11, 16'h0ABC, 16'h0365, 8'd0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'd15, 16'h8001, 16'h7FFE, 8'd0},
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'd4,  16'h0013, 16'h000A, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [8:0]  ctl_wdata = '0;
    logic [7:0]  div_half = '0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = '0;
    logic        rx_read = 1'b0;
    logic        err_clr = 1'b0;
    logic        sclk_in = 1'b0;
    logic        sdi_tb = 1'b0;
    logic        loop = 1'b0;
    logic        sdi;
    logic        sclk_out, sdo, busy, rx_valid, tx_err, rx_ovr;
    logic [15:0] rx_data;

    int nchk = 0;
    int nfail = 0;
    int vcount = 0;

    assign sdi = loop ? sdo : sdi_tb;

    always #2.5 clk = ~clk;

    sync_serial_engine i_sync_serial_engine (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .div_half(div_half), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_read(rx_read), .err_clr(err_clr), .sclk_in(sclk_in), .sdi(sdi),
        .sclk_out(sclk_out), .sdo(sdo), .busy(busy), .rx_data(rx_data),
        .rx_valid(rx_valid), .tx_err(tx_err), .rx_ovr(rx_ovr)
    );

    always @(negedge clk) if (rx_valid === 1'b1) vcount++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lmask(input int len);
        return 16'((32'd1 << len) - 1);
    endfunction

    task automatic write_ctl(input logic [3:0] w, input logic msb, input logic cpha,
                             input logic cpol, input logic master, input logic en);
        @(negedge clk);
        ctl_wdata = {w, msb, cpha, cpol, master, en};
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic pulse_tx(input logic [15:0] d);
        @(negedge clk);
        tx_data = d;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (busy === 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic run_master(input vec_t v);
        int len = int'(v.width) + 1;
        int e = 0;
        int hp = 0;
        int last = 0;
        int cyc = 0;
        logic [15:0] cap = '0;
        logic ps, pd;
        pulse_tx(v.tx);
        ps = sclk_out;
        pd = sdo;
        while (cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (sclk_out !== ps) begin
                if (e == 1) hp = cyc - last;
                last = cyc;
                if (((e % 2) == 0) == v.cpha) begin
                    int idx = e / 2;
                    cap[v.msb ? len - 1 - idx : idx] = pd;
                end
                e++;
            end
            ps = sclk_out;
            pd = sdo;
            if (busy !== 1'b1) break;
        end
        chk("R2 edge count", e, 2 * len);
        chk("R6 half period", hp, int'(v.div) + 1);
        chk("R5 serial order", cap, v.tx & lmask(len));
        chk("R4 loopback word", rx_data, v.tx & lmask(len));
    endtask

    task automatic run_slave(input vec_t v);
        int len = int'(v.width) + 1;
        logic [15:0] cap = '0;
        pulse_tx(v.tx);
        for (int i = 0; i < len; i++) begin
            int pos = v.msb ? len - 1 - i : i;
            repeat (H2) @(negedge clk);
            if (v.cpha) sdi_tb = v.pat[pos];
            repeat (H2) @(negedge clk);
            if (v.cpha) cap[pos] = sdo;
            sclk_in = ~v.cpol;
            repeat (H2) @(negedge clk);
            if (!v.cpha) sdi_tb = v.pat[pos];
            repeat (H2) @(negedge clk);
            if (!v.cpha) cap[pos] = sdo;
            sclk_in = v.cpol;
        end
        repeat (8) @(negedge clk);
        chk("R7 slave frame ends", busy, 1'b0);
        chk("R4 slave receive edge", rx_data, v.pat & lmask(len));
        chk("R5 slave serial order", cap, v.tx & lmask(len));
    endtask

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 1'b0);
        chk("R1 tx_err", tx_err, 1'b0);
        chk("R1 rx_ovr", rx_ovr, 1'b0);
        chk("R1 rx_valid", rx_valid, 1'b0);
        chk("R1 sclk_out", sclk_out, 1'b0);
        pulse_tx(16'h00FF);
        repeat (3) @(negedge clk);
        chk("R1 disabled after reset", busy, 1'b0);

        for (int n = 0; n < NV; n++) begin
            vec_t v = VECS[n];
            div_half = v.div;
            loop = v.master;
            sclk_in = v.cpol;
            sdi_tb = 1'b0;
            write_ctl(v.width, v.msb, v.cpha, v.cpol, v.master, 1'b1);
            repeat (4) @(negedge clk);
            chk("R3 idle level before", sclk_out, v.cpol);
            vcount = 0;
            if (v.master) run_master(v);
            else          run_slave(v);
            repeat (2) @(negedge clk);
            chk("R9 one valid pulse", vcount, 1);
            chk("R3 idle level after", sclk_out, v.cpol);
            pulse_read();
            chk("R11 no overrun when read", rx_ovr, 1'b0);
        end

        // R2 reserved width code
        loop = 1'b1;
        div_half = 8'd1;
        write_ctl(4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        pulse_tx(16'h1234);
        repeat (4) @(negedge clk);
        chk("R2 width code 0 no start", busy, 1'b0);
        chk("R2 width code 0 clock still", sclk_out, 1'b0);

        // R8 disabled ignores write
        write_ctl(4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        pulse_tx(16'h0055);
        repeat (4) @(negedge clk);
        chk("R8 disabled no start", busy, 1'b0);

        // R8 abort by clearing enable
        div_half = 8'd3;
        write_ctl(4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        pulse_tx(16'h0055);
        repeat (10) @(negedge clk);
        chk("R8 running before abort", busy, 1'b1);
        write_ctl(4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        chk("R8 abort clears busy", busy, 1'b0);
        chk("R8 abort idle clock", sclk_out, 1'b1);

        // R10 write while busy
        div_half = 8'd1;
        write_ctl(4'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        pulse_tx(16'h003C);
        repeat (6) @(negedge clk);
        pulse_tx(16'h00FF);
        chk("R10 tx_err set", tx_err, 1'b1);
        wait_idle();
        chk("R10 frame unchanged", rx_data, 16'h003C);
        chk("R10 tx_err holds", tx_err, 1'b1);
        pulse_clr();
        chk("R10 tx_err cleared", tx_err, 1'b0);

        // R11 overrun: previous word not read
        pulse_tx(16'h0055);
        wait_idle();
        @(negedge clk);
        chk("R11 overrun set", rx_ovr, 1'b1);
        chk("R11 newest word kept", rx_data, 16'h0055);
        pulse_read();
        chk("R11 overrun survives read", rx_ovr, 1'b1);
        pulse_clr();
        chk("R11 overrun cleared", rx_ovr, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule